// File: doc/BRIEF.md
# Compressed Instruction Fetch Aligner

This block sits between the fetch packet queue and the decoder of a 64-bit core whose instruction set mixes 16-bit and 32-bit encodings. Every fetch packet arrives together with the full 64-byte cacheline that holds it. A packet names one 4-byte window of that line and carries two branch predictions, one for each halfword of the window. The aligner cuts the window into instructions and hands decode one instruction per handshake, together with the instruction's address and the prediction that belongs to its first halfword.

A 32-bit instruction may begin in the upper half of a window. When the halfword that completes it is in the same line, the aligner reads it straight from the line and marks the lower half of the next window as already consumed. When the window is the last one in the line, the aligner parks the upper halfword in a residue register, takes the packet, and finishes the instruction with the lower half of the next packet. That costs exactly one empty cycle. A flush drops the residue and all partial-consumption state at once.

Top module: `cfa_aligner`

## Requirements
- R1: A window whose lower halfword is not compressed goes out in one transfer as the whole 32-bit word, with the window's word-aligned address and the lower-half prediction, and the packet is taken in that cycle.
- R2: A window holding two compressed halfwords produces two transfers in consecutive handshakes: first the lower half with the window address and lower prediction, then the upper half with address+2 and upper prediction. The packet is taken with the second.
- R3: When the upper halfword starts a 32-bit instruction and the window is not the last in its line, the instruction is the upper half in bits 15:0 joined with the next word's lower half in bits 31:16. It is sent at address+2 with the upper prediction and no empty cycle, and the lower half of the following packet is skipped.
- R4: A packet whose address has bit 1 set (a redirect to a halfword-aligned target) ignores the lower halfword of its window and starts at the upper halfword with the upper prediction.
- R5: A 32-bit instruction starting at line offset 0x3E is held back, and the packet is taken without output. It is sent once the next packet arrives, joined with that packet's lower halfword, carrying its own address and prediction. With packets and decode never stalling, this adds exactly one cycle.
- R6: A halfword is compressed when its bits 1:0 are not 2'b11. The compressed flag equals that test on the instruction field, and bits 31:16 of the field are zero for compressed instructions.
- R7: While flush is high, no instruction is offered and no packet is taken. The residue and the skip of the next lower half are cleared, so the next packet is decoded as a fresh window.
- R8: While decode holds ready low, the offered instruction, address and prediction stay unchanged and no packet is taken.
- R9: In reset, and with no packet present, the decode output is not valid and no packet is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Drop residue and partial-window state |
| pkt_valid | input | 1 | Fetch packet and its line are present |
| pkt_ready | output | 1 | Packet is taken this cycle |
| pkt_pc | input | XLEN | Packet address, halfword aligned |
| pkt_pred_lo | input | PRED_W | Prediction for the window's lower halfword |
| pkt_pred_hi | input | PRED_W | Prediction for the window's upper halfword |
| pkt_line | input | LINE_BYTES*8 | Cacheline containing the window |
| dec_valid | output | 1 | Instruction offered to decode |
| dec_ready | input | 1 | Decode accepts the instruction |
| dec_instr | output | 32 | Instruction, upper half zero when compressed |
| dec_short | output | 1 | Instruction is compressed |
| dec_pc | output | XLEN | Instruction address |
| dec_pred | output | PRED_W | Prediction of the instruction's first halfword |

## Verification
The assertions take for granted that the packet source holds its address, predictions and line steady while a packet is offered and not taken. They also assume packets follow one another in address order between flushes, and that packet addresses are never odd. The stimulus keeps to this. The driver keeps a packet on the inputs until it sees it taken. Every stream is built as consecutive windows from one start address, and flushes are placed only between streams. Decode ready and packet gaps are varied pseudo-randomly, so the hold-while-stalled checks see many stall lengths.

// File: rtl/cfa_pkg.sv
package cfa_pkg;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_LO16,
        ACT_FULL32,
        ACT_HI16,
        ACT_HI32,
        ACT_PARK,
        ACT_RESID
    } act_e;

    typedef struct packed {
        logic res_v;
        logic cur_hi;
        logic skip_lo;
    } flags_t;

    function automatic logic is_short(input logic [15:0] h);
        return h[1:0] != 2'b11;
    endfunction

endpackage

// File: rtl/cfa_window.sv
module cfa_window #(
    parameter int LINE_BYTES = 64,
    localparam int WORDS  = LINE_BYTES / 4,
    localparam int IDX_W  = $clog2(WORDS),
    localparam int LINE_W = LINE_BYTES * 8
) (
    input  logic [LINE_W-1:0] line,
    input  logic [IDX_W-1:0]  idx,
    output logic [31:0]       word,
    output logic [15:0]       next_half,
    output logic              next_in_line
);
    logic [31:0] words [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        assign words[g] = line[g*32 +: 32];
    end

    logic [IDX_W-1:0] idx_nx;
    assign idx_nx       = idx + IDX_W'(1);
    assign next_in_line = (idx != IDX_W'(WORDS - 1));
    assign word         = words[idx];
    assign next_half    = next_in_line ? words[idx_nx][15:0] : 16'h0000;

endmodule

// File: rtl/cfa_ctrl.sv
module cfa_ctrl
    import cfa_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int PRED_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              pkt_valid,
    output logic              pkt_ready,
    input  logic [XLEN-1:0]   pkt_pc,
    input  logic [PRED_W-1:0] pkt_pred_lo,
    input  logic [PRED_W-1:0] pkt_pred_hi,
    input  logic [31:0]       word,
    input  logic [15:0]       next_half,
    input  logic              next_in_line,
    output logic              dec_valid,
    input  logic              dec_ready,
    output logic [31:0]       dec_instr,
    output logic              dec_short,
    output logic [XLEN-1:0]   dec_pc,
    output logic [PRED_W-1:0] dec_pred
);
    flags_t            st;
    logic [15:0]       res_half;
    logic [XLEN-1:0]   res_pc;
    logic [PRED_W-1:0] res_pred;

    act_e            act;
    logic [XLEN-1:0] base;
    logic [15:0]     lo, hi;
    logic            start_hi, fire;

    assign base     = {pkt_pc[XLEN-1:2], 2'b00};
    assign lo       = word[15:0];
    assign hi       = word[31:16];
    assign start_hi = pkt_pc[1] | st.skip_lo | st.cur_hi;

    always_comb begin
        act = ACT_NONE;
        if (pkt_valid && !flush) begin
            if (st.res_v)            act = ACT_RESID;
            else if (!start_hi)      act = is_short(lo) ? ACT_LO16 : ACT_FULL32;
            else if (is_short(hi))   act = ACT_HI16;
            else if (next_in_line)   act = ACT_HI32;
            else                     act = ACT_PARK;
        end
    end

    always_comb begin
        dec_instr = 32'h0;
        dec_short = 1'b0;
        dec_pc    = base;
        dec_pred  = pkt_pred_lo;
        case (act)
            ACT_RESID: begin
                dec_instr = {lo, res_half};
                dec_pc    = res_pc;
                dec_pred  = res_pred;
            end
            ACT_LO16: begin
                dec_instr = {16'h0000, lo};
                dec_short = 1'b1;
            end
            ACT_FULL32: dec_instr = word;
            ACT_HI16: begin
                dec_instr = {16'h0000, hi};
                dec_short = 1'b1;
                dec_pc    = base + XLEN'(2);
                dec_pred  = pkt_pred_hi;
            end
            ACT_HI32: begin
                dec_instr = {next_half, hi};
                dec_pc    = base + XLEN'(2);
                dec_pred  = pkt_pred_hi;
            end
            default: ;
        endcase
    end

    assign dec_valid = (act != ACT_NONE) && (act != ACT_PARK);
    assign fire      = dec_valid && dec_ready;
    assign pkt_ready = (act == ACT_PARK) ||
                       (fire && (act == ACT_FULL32 || act == ACT_HI16 || act == ACT_HI32));

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= '0;
            res_half <= '0;
            res_pc   <= '0;
            res_pred <= '0;
        end else if (flush) begin
            st <= '0;
        end else begin
            case (act)
                ACT_RESID: if (fire) begin
                    st.res_v  <= 1'b0;
                    st.cur_hi <= 1'b1;
                end
                ACT_LO16: if (fire) st.cur_hi <= 1'b1;
                ACT_FULL32, ACT_HI16: if (fire) begin
                    st.cur_hi  <= 1'b0;
                    st.skip_lo <= 1'b0;
                end
                ACT_HI32: if (fire) begin
                    st.cur_hi  <= 1'b0;
                    st.skip_lo <= 1'b1;
                end
                ACT_PARK: begin
                    st.res_v   <= 1'b1;
                    st.cur_hi  <= 1'b0;
                    st.skip_lo <= 1'b0;
                    res_half   <= hi;
                    res_pc     <= base + XLEN'(2);
                    res_pred   <= pkt_pred_hi;
                end
                default: ;
            endcase
        end
    end

    // R6: flag agrees with the emitted encoding
    a_r6_flag_matches: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> (dec_short == (dec_instr[1:0] != 2'b11)));

    // R6: compressed instructions carry a zero upper half
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_short) |-> (dec_instr[31:16] == 16'h0000));

    // R7: nothing offered or taken during flush
    a_r7_flush_quiet: assert property (@(posedge clk) disable iff (rst)
        flush |-> (!dec_valid && !pkt_ready));

    // R8: stalled output holds
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !dec_ready && !flush) |=>
        (flush || (dec_valid && $stable(dec_instr) && $stable(dec_pc) && $stable(dec_pred))));

    // R8: no packet taken while decode refuses
    a_r8_no_take: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !dec_ready) |-> !pkt_ready);

    // R5: a silent take is followed by the joined 32-bit instruction
    a_r5_park_then_join: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && pkt_ready && !dec_valid) |=>
        (flush || !pkt_valid || (dec_valid && !dec_short)));

    // R4: packet addresses are halfword aligned
    a_r4_half_aligned: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> !pkt_pc[0]);

endmodule

// File: rtl/cfa_aligner.sv
module cfa_aligner #(
    parameter int XLEN       = 64,
    parameter int PRED_W     = 4,
    parameter int LINE_BYTES = 64,
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int IDX_W     = $clog2(LINE_BYTES / 4)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              pkt_valid,
    output logic              pkt_ready,
    input  logic [XLEN-1:0]   pkt_pc,
    input  logic [PRED_W-1:0] pkt_pred_lo,
    input  logic [PRED_W-1:0] pkt_pred_hi,
    input  logic [LINE_W-1:0] pkt_line,
    output logic              dec_valid,
    input  logic              dec_ready,
    output logic [31:0]       dec_instr,
    output logic              dec_short,
    output logic [XLEN-1:0]   dec_pc,
    output logic [PRED_W-1:0] dec_pred
);
    logic [31:0] word;
    logic [15:0] next_half;
    logic        next_in_line;

    cfa_window #(.LINE_BYTES(LINE_BYTES)) u_window (
        .line         (pkt_line),
        .idx          (pkt_pc[IDX_W+1:2]),
        .word         (word),
        .next_half    (next_half),
        .next_in_line (next_in_line)
    );

    cfa_ctrl #(.XLEN(XLEN), .PRED_W(PRED_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .flush        (flush),
        .pkt_valid    (pkt_valid),
        .pkt_ready    (pkt_ready),
        .pkt_pc       (pkt_pc),
        .pkt_pred_lo  (pkt_pred_lo),
        .pkt_pred_hi  (pkt_pred_hi),
        .word         (word),
        .next_half    (next_half),
        .next_in_line (next_in_line),
        .dec_valid    (dec_valid),
        .dec_ready    (dec_ready),
        .dec_instr    (dec_instr),
        .dec_short    (dec_short),
        .dec_pc       (dec_pc),
        .dec_pred     (dec_pred)
    );

endmodule

// File: tb/cfa_aligner_tb.sv
module cfa_aligner_tb;
    localparam logic [63:0] BASE = 64'h0000_0000_8000_0000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         flush = 1'b0;
    logic         pkt_valid = 1'b0;
    logic         pkt_ready;
    logic [63:0]  pkt_pc = '0;
    logic [3:0]   pkt_pred_lo = '0, pkt_pred_hi = '0;
    logic [511:0] pkt_line = '0;
    logic         dec_valid;
    logic         dec_ready = 1'b1;
    logic [31:0]  dec_instr;
    logic         dec_short;
    logic [63:0]  dec_pc;
    logic [3:0]   dec_pred;

    cfa_aligner u_dut (
        .clk(clk), .rst(rst), .flush(flush),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_pc(pkt_pc),
        .pkt_pred_lo(pkt_pred_lo), .pkt_pred_hi(pkt_pred_hi), .pkt_line(pkt_line),
        .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_instr(dec_instr),
        .dec_short(dec_short), .dec_pc(dec_pc), .dec_pred(dec_pred)
    );

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    logic [15:0] mem [128];
    int          pkts [$];
    logic [31:0] e_instr [$];
    logic [63:0] e_pc [$];
    logic [3:0]  e_pred [$];
    string       e_tag [$];
    bit          took_pkt = 0, stall_prev = 0;
    logic [31:0] stall_instr;
    logic [63:0] stall_pc;
    int          first_h = -1, last_h = -1;
    bit          done = 0;

    always @(posedge clk) cyc++;

    function automatic logic [3:0] pred_of(int a);
        return 4'((a >> 1) & 15);
    endfunction

    task automatic chk(bit ok, string req, string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s", req, msg);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            took_pkt = pkt_valid && pkt_ready;
            if (stall_prev && !flush)
                chk(dec_valid && dec_instr == stall_instr && dec_pc == stall_pc, "R8",
                    $sformatf("stalled output changed: act %h@%h exp %h@%h",
                              dec_instr, dec_pc, stall_instr, stall_pc));
            stall_prev  = dec_valid && !dec_ready && !flush;
            stall_instr = dec_instr;
            stall_pc    = dec_pc;
            if (dec_valid && dec_ready) begin
                if (e_instr.size() == 0) begin
                    chk(0, "R1", $sformatf("extra output act %h@%h exp none", dec_instr, dec_pc));
                end else begin
                    logic [31:0] ei;
                    logic [63:0] ep;
                    logic [3:0]  ed;
                    string       tg;
                    ei = e_instr.pop_front(); ep = e_pc.pop_front();
                    ed = e_pred.pop_front();  tg = e_tag.pop_front();
                    chk(dec_instr == ei && dec_pc == ep && dec_pred == ed &&
                        dec_short == (ei[1:0] != 2'b11), tg,
                        $sformatf("instr act %h exp %h pc act %h exp %h pred act %h exp %h short act %b",
                                  dec_instr, ei, dec_pc, ep, dec_pred, ed, dec_short));
                end
                if (first_h < 0) first_h = cyc;
                last_h = cyc;
            end
        end
    end

    task automatic place(int a, bit is32, string tg);
        logic [31:0] w;
        w = $urandom;
        if (is32) begin
            w[1:0] = 2'b11;
            mem[a/2] = w[15:0];
            mem[a/2+1] = w[31:16];
            e_instr.push_back(w);
        end else begin
            if (w[1:0] == 2'b11) w[0] = 1'b0;
            mem[a/2] = w[15:0];
            e_instr.push_back({16'h0000, w[15:0]});
        end
        e_pc.push_back(BASE + 64'(a));
        e_pred.push_back(pred_of(a));
        e_tag.push_back(tg);
    endtask

    function automatic string tag_of(int a, bit is32, bit first);
        if (first && (a % 4 == 2)) return "R4";
        if (is32 && (a % 64 == 62)) return "R5";
        if (is32 && (a % 4 == 2))   return "R3";
        if (is32)                   return "R1";
        if (a % 4 == 0)             return "R6";
        return "R2";
    endfunction

    task automatic mkpkts(int start, int endb);
        pkts.delete();
        for (int w = start / 4; w <= (endb - 1) / 4; w++)
            pkts.push_back(w == start / 4 ? start : w * 4);
        if (start % 4 == 2) mem[(start-2)/2] = 16'hFFFF;
    endtask

    // mode 0: all 32-bit, 1: all compressed, 2: mixed
    task automatic gen(int start, int endb, int mode);
        int  a;
        bit  first;
        a = start;
        first = 1;
        while (a < endb) begin
            bit is32;
            is32 = (mode == 0) ? 1'b1 : (mode == 1) ? 1'b0 : 1'($urandom % 2);
            if (a + 4 > endb) is32 = 1'b0;
            place(a, is32, tag_of(a, is32, first));
            a += is32 ? 4 : 2;
            first = 0;
        end
        mkpkts(start, endb);
    endtask

    task automatic drive_pkt(int addr);
        pkt_valid   = 1'b1;
        pkt_pc      = BASE + 64'(addr);
        pkt_pred_lo = pred_of(addr & ~3);
        pkt_pred_hi = pred_of((addr & ~3) + 2);
        for (int i = 0; i < 32; i++)
            pkt_line[i*16 +: 16] = mem[((addr >> 6) << 5) + i];
    endtask

    task automatic run(int vgap, int rgap);
        int idx = 0;
        int n = 0;
        took_pkt = 0;
        while ((idx < pkts.size() || e_instr.size() > 0) && n < 4000) begin
            @(posedge clk); #1;
            if (took_pkt) begin
                idx++;
                pkt_valid = 1'b0;
            end
            took_pkt = 0;
            if (idx < pkts.size() && (pkt_valid || ($urandom % 100) >= vgap))
                drive_pkt(pkts[idx]);
            else
                pkt_valid = 1'b0;
            dec_ready = (($urandom % 100) >= rgap);
            n++;
        end
        if (idx < pkts.size()) begin @(posedge clk); #1; end
        pkt_valid = 1'b0;
        dec_ready = 1'b1;
        chk(e_instr.size() == 0, "R1",
            $sformatf("stream not drained: act %0d left exp 0", e_instr.size()));
    endtask

    task automatic do_flush(int next_addr);
        @(posedge clk); #1;
        flush = 1'b1;
        dec_ready = 1'b1;
        drive_pkt(next_addr);
        @(negedge clk);
        chk(!dec_valid && !pkt_ready, "R7",
            $sformatf("activity during flush: act valid %b ready %b exp 0 0", dec_valid, pkt_ready));
        @(posedge clk); #1;
        flush = 1'b0;
        pkt_valid = 1'b0;
        stall_prev = 0;
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!dec_valid && !pkt_ready, "R9",
            $sformatf("in reset: act %b %b exp 0 0", dec_valid, pkt_ready));
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        chk(!dec_valid && !pkt_ready, "R9",
            $sformatf("idle after reset: act %b %b exp 0 0", dec_valid, pkt_ready));

        gen(0, 64, 0);   run(0, 0);     // R1
        gen(64, 128, 1); run(20, 20);   // R2, R6
        for (int s = 0; s < 6; s++) begin
            gen(0, 240, 2); run(25, 35); // R3, R5, R8 mixed
        end
        gen(18, 64, 2);  run(10, 30);   // R4
        gen(130, 200, 2); run(0, 40);   // R4 from 0x82

        // R4 + R5: redirect straight onto offset 0x3E with a 32-bit instruction
        place(62, 1, "R4"); place(66, 0, "R5"); place(68, 1, "R5");
        mkpkts(62, 72); run(0, 0);

        // R3: no empty cycle for an in-line straddle
        place(0, 0, "R6"); place(2, 1, "R3"); place(6, 0, "R2"); place(8, 1, "R1");
        mkpkts(0, 12);
        first_h = -1; run(0, 0);
        chk(last_h - first_h + 1 == 4, "R3",
            $sformatf("span act %0d exp 4", last_h - first_h + 1));

        // R5: exactly one empty cycle for a line-end straddle
        place(52, 1, "R1"); place(56, 0, "R6"); place(58, 0, "R2");
        place(60, 0, "R6"); place(62, 1, "R5"); place(66, 0, "R2"); place(68, 1, "R1");
        mkpkts(52, 72);
        first_h = -1; run(0, 0);
        chk(last_h - first_h + 1 == 8, "R5",
            $sformatf("span act %0d exp 8", last_h - first_h + 1));

        // R7: flush while a residue is parked
        place(124, 0, "R6"); place(126, 1, "R5");
        e_instr.pop_back(); e_pc.pop_back(); e_pred.pop_back(); e_tag.pop_back();
        pkts.delete(); pkts.push_back(124);
        run(0, 0);
        place(128, 1, "R7"); place(132, 0, "R7"); place(134, 0, "R7");
        do_flush(128);
        mkpkts(128, 136); run(0, 0);

        // R7: flush while the next lower half is marked consumed
        place(16, 0, "R6"); place(18, 1, "R3");
        pkts.delete(); pkts.push_back(16);
        run(0, 0);
        place(32, 1, "R7"); place(36, 0, "R7"); place(38, 0, "R7");
        do_flush(32);
        mkpkts(32, 40); run(0, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog expired: act running exp finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule